// File: doc/BRIEF.md
# Quad SPI Indirect Read Sequencer

This block runs one read frame against a serial NOR flash over a four-line SPI bus. The host sets the configuration inputs: opcode, address length (three or four bytes), an optional mode byte, the dummy clock count, the receive byte count, single or quad line use, and a prefetch enable. It then writes the address bytes into an 8-entry transmit FIFO. The first address byte in the FIFO starts the frame. The block clocks out the opcode, the address, the optional mode byte and the dummy clocks, then shifts read data into an 8-entry receive FIFO that the host drains.

Each pulse on `sck_tick` is one bit slot. An external divider supplies the pulse. `qspi_sck` pulses in every slot that the block actually executes, and the flash pins are sampled at the clock edge of that slot. A nonzero receive count ends the frame by itself. A count of zero reads with no end. In that mode the bus clock stops whenever the receive FIFO is full, and the host ends the frame with a hold request, a flush and a release.

Top module: `qspi_indirect_rd`

## Requirements
- R1: After reset, `st_idle`=1, `qspi_cs_n`=1, `qspi_io_oe`=0, `st_rx_empty`=1, `st_tx_nf`=1 and `st_stall`=0.
- R2: A frame starts only when `cfg_prefetch`=1 and the transmit FIFO holds at least one byte. While `cfg_prefetch`=0, a written byte leaves `qspi_cs_n` high.
- R3: The frame opens with 8 slots carrying `cfg_opcode` MSB first on `io[0]` with `qspi_io_oe`=4'b0001, whatever `cfg_quad` is.
- R4: Next come 3 address bytes (`cfg_addr4`=0) or 4 address bytes (`cfg_addr4`=1), popped from the transmit FIFO in write order. Each byte is sent MSB first, as 8 slots on `io[0]` with oe=4'b0001 when `cfg_quad`=0, or as 2 slots of high nibble then low nibble on `io[3:0]` with oe=4'hF when `cfg_quad`=1. No slot runs while the transmit FIFO is empty.
- R5: When `cfg_perf_en`=1, `cfg_perf_byte` follows the address in the same line format.
- R6: Then `cfg_dummy` slots run with the lines released and the inputs not sampled. A value of 0 skips this phase.
- R7: In data slots the block samples `io[1]` (`cfg_quad`=0, 8 slots per byte) or `io[3:0]` (`cfg_quad`=1, high nibble first). It pushes each complete byte into the receive FIFO, and `rx_data` shows the oldest byte.
- R8: With `cfg_rx_count`=N, where N>0, no slot runs after N bytes. `qspi_cs_n` stays low and `st_idle` stays 0 until the hold handshake.
- R9: With `cfg_rx_count`=0, `st_stall`=1 while the receive FIFO is full, and no slot runs in that time.
- R10: Setting `cs_hold`=1 at a byte boundary, or after a counted read, makes `st_idle`=1 with `qspi_cs_n` still low. `rx_flush` empties the receive FIFO and clears `st_stall`. Setting `cs_hold`=0 then raises `qspi_cs_n`.
- R11: From the dummy phase until `qspi_cs_n` rises, `qspi_io_oe`=0.
- R12: `st_tx_nf` falls when 8 bytes are held in the transmit FIFO. `st_rx_empty` is 1 exactly when the receive FIFO holds no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_tick | input | 1 | Bit-slot enable from the clock divider |
| cfg_opcode | input | 8 | Instruction byte |
| cfg_addr4 | input | 1 | 1 = four address bytes, 0 = three |
| cfg_quad | input | 1 | 1 = address, mode byte and data on four lines |
| cfg_perf_en | input | 1 | Send the mode byte |
| cfg_perf_byte | input | 8 | Mode byte value |
| cfg_dummy | input | DUMMY_W | Dummy slot count |
| cfg_rx_count | input | CNT_W | Bytes to read, 0 = unbounded |
| cfg_prefetch | input | 1 | Allow a frame to start |
| cs_hold | input | 1 | Hold request and release control |
| rx_flush | input | 1 | Empty the receive FIFO |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Address byte |
| rx_rd | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Oldest received byte |
| st_idle | output | 1 | Idle status |
| st_tx_nf | output | 1 | Transmit FIFO not full |
| st_rx_empty | output | 1 | Receive FIFO empty |
| st_stall | output | 1 | Unbounded read stalled on a full FIFO |
| qspi_cs_n | output | 1 | Chip select, active low |
| qspi_sck | output | 1 | Serial clock pulse, one per executed slot |
| qspi_io_out | output | 4 | Data line output values |
| qspi_io_oe | output | 4 | Data line output enables |
| qspi_io_in | input | 4 | Data line input values |

## Verification
A wrong phase register shows at the pins on the very next executed slot. Either the enable pattern moves away from 0001/F/0, or the slot count between the chip select falling and the first released line moves off the expected total. A slot counter that is off by one misplaces a nibble or a bit. The first byte read back from the receive FIFO then differs, within one byte time. A wrong stall or hold state shows as `qspi_sck` pulses where none are allowed. After the last byte or the fill of the receive FIFO, the total slot count stops at the wrong value, and the bench reads that count a few dozen cycles later.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_PERF, PH_DUMMY, PH_DATA, PH_DONE, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [3:0] oe;
        logic [3:0] dout;
    } pin_drive_t;

    // Pin values for one slot of an outgoing byte, MSB first.
    function automatic pin_drive_t drive_bits(input logic [7:0] b, input logic quad,
                                              input logic [2:0] idx);
        pin_drive_t p;
        if (quad) begin
            p.oe   = 4'hF;
            p.dout = idx[0] ? b[3:0] : b[7:4];
        end else begin
            p.oe   = 4'b0001;
            p.dout = {3'b000, b[3'd7 - idx]};
        end
        return p;
    endfunction

endpackage

// File: rtl/qspi_rd_fifo.sv
module qspi_rd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   fill;
    logic          do_push, do_pop;

    assign full    = (fill == (AW+1)'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
    import qspi_rd_pkg::*;
#(
    parameter int DUMMY_W = 5,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck_tick,
    input  logic [7:0]         cfg_opcode,
    input  logic               cfg_addr4,
    input  logic               cfg_quad,
    input  logic               cfg_perf_en,
    input  logic [7:0]         cfg_perf_byte,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [CNT_W-1:0]   cfg_rx_count,
    input  logic               cfg_prefetch,
    input  logic               cs_hold,
    input  logic               tx_empty,
    input  logic [7:0]         tx_head,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [7:0]         rx_wdata,
    input  logic [3:0]         io_in,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    output logic               sck,
    output logic               cs_n,
    output logic               idle,
    output logic               stall,
    output phase_e             phase
);
    localparam int CW = (DUMMY_W > 3) ? DUMMY_W : 3;

    phase_e         st;
    logic [CW-1:0]  cnt;
    logic [1:0]     abyte;
    logic [CNT_W-1:0] nrx;
    logic [7:0]     rx_sh;

    logic           quad_eff, last_slot, can_run, run, hold_stop, unbounded;
    logic [7:0]     cur_byte, rx_next;
    logic [CW-1:0]  slot_last, dum_last;
    pin_drive_t     pd;
    phase_e         after_perf, after_addr;

    assign unbounded = (cfg_rx_count == '0);
    assign quad_eff  = (st == PH_CMD) ? 1'b0 : cfg_quad;
    assign slot_last = quad_eff ? CW'(1) : CW'(7);
    assign dum_last  = CW'(cfg_dummy) - CW'(1);
    assign last_slot = (st == PH_DUMMY) ? (cnt == dum_last) : (cnt == slot_last);
    assign hold_stop = (st == PH_DATA) && unbounded && cs_hold && (cnt == '0);

    always_comb begin
        case (st)
            PH_CMD:   cur_byte = cfg_opcode;
            PH_ADDR:  cur_byte = tx_head;
            PH_PERF:  cur_byte = cfg_perf_byte;
            default:  cur_byte = 8'h00;
        endcase
        case (st)
            PH_CMD, PH_PERF, PH_DUMMY: can_run = 1'b1;
            PH_ADDR:  can_run = !tx_empty;
            PH_DATA:  can_run = !hold_stop && !((cnt == '0) && rx_full);
            default:  can_run = 1'b0;
        endcase
    end

    assign run        = sck_tick && can_run;
    assign pd         = drive_bits(cur_byte, quad_eff, cnt[2:0]);
    assign after_perf = (cfg_dummy == '0) ? PH_DATA : PH_DUMMY;
    assign after_addr = cfg_perf_en ? PH_PERF : after_perf;
    assign rx_next    = cfg_quad ? {rx_sh[3:0], io_in} : {rx_sh[6:0], io_in[1]};

    always_comb begin
        if (st == PH_CMD || st == PH_ADDR || st == PH_PERF) begin
            io_out = pd.dout;
            io_oe  = pd.oe;
        end else begin
            io_out = 4'h0;
            io_oe  = 4'h0;
        end
    end

    assign tx_pop   = run && (st == PH_ADDR) && last_slot;
    assign rx_push  = run && (st == PH_DATA) && last_slot;
    assign rx_wdata = rx_next;
    assign sck      = run;
    assign cs_n     = (st == PH_IDLE);
    assign idle     = (st == PH_IDLE) || (st == PH_HOLD);
    assign stall    = unbounded && rx_full && (st == PH_DATA || st == PH_HOLD);
    assign phase    = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            cnt   <= '0;
            abyte <= '0;
            nrx   <= '0;
            rx_sh <= '0;
        end else begin
            case (st)
                PH_IDLE: if (cfg_prefetch && !tx_empty) begin
                    st    <= PH_CMD;
                    cnt   <= '0;
                    abyte <= '0;
                    nrx   <= '0;
                end
                PH_DONE: if (cs_hold) st <= PH_HOLD;
                PH_HOLD: if (!cs_hold) st <= PH_IDLE;
                default: begin
                    if (hold_stop) begin
                        st <= PH_HOLD;
                    end else if (run) begin
                        cnt <= last_slot ? '0 : cnt + CW'(1);
                        if (st == PH_DATA) rx_sh <= rx_next;
                        if (last_slot) begin
                            case (st)
                                PH_CMD:   st <= PH_ADDR;
                                PH_ADDR: begin
                                    abyte <= abyte + 2'd1;
                                    if (abyte == (cfg_addr4 ? 2'd3 : 2'd2)) st <= after_addr;
                                end
                                PH_PERF:  st <= after_perf;
                                PH_DUMMY: st <= PH_DATA;
                                PH_DATA: begin
                                    nrx <= nrx + CNT_W'(1);
                                    if (!unbounded && (nrx + CNT_W'(1) == cfg_rx_count))
                                        st <= PH_DONE;
                                end
                                default: st <= st;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qspi_indirect_rd.sv
module qspi_indirect_rd
    import qspi_rd_pkg::*;
#(
    parameter int DUMMY_W    = 5,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck_tick,
    input  logic [7:0]         cfg_opcode,
    input  logic               cfg_addr4,
    input  logic               cfg_quad,
    input  logic               cfg_perf_en,
    input  logic [7:0]         cfg_perf_byte,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [CNT_W-1:0]   cfg_rx_count,
    input  logic               cfg_prefetch,
    input  logic               cs_hold,
    input  logic               rx_flush,
    input  logic               tx_wr,
    input  logic [7:0]         tx_data,
    input  logic               rx_rd,
    output logic [7:0]         rx_data,
    output logic               st_idle,
    output logic               st_tx_nf,
    output logic               st_rx_empty,
    output logic               st_stall,
    output logic               qspi_cs_n,
    output logic               qspi_sck,
    output logic [3:0]         qspi_io_out,
    output logic [3:0]         qspi_io_oe,
    input  logic [3:0]         qspi_io_in
);
    logic       tx_full, tx_empty, tx_pop, rx_full, rx_push;
    logic [7:0] tx_head, rx_wdata;
    phase_e     seq_phase;

    qspi_rd_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst(rst), .push(tx_wr), .wdata(tx_data), .pop(tx_pop),
        .flush(1'b0), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    qspi_rd_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata), .pop(rx_rd),
        .flush(rx_flush), .rdata(rx_data), .full(rx_full), .empty(st_rx_empty)
    );

    qspi_rd_seq #(.DUMMY_W(DUMMY_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .sck_tick(sck_tick),
        .cfg_opcode(cfg_opcode), .cfg_addr4(cfg_addr4), .cfg_quad(cfg_quad),
        .cfg_perf_en(cfg_perf_en), .cfg_perf_byte(cfg_perf_byte),
        .cfg_dummy(cfg_dummy), .cfg_rx_count(cfg_rx_count),
        .cfg_prefetch(cfg_prefetch), .cs_hold(cs_hold),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .io_in(qspi_io_in), .io_out(qspi_io_out), .io_oe(qspi_io_oe),
        .sck(qspi_sck), .cs_n(qspi_cs_n), .idle(st_idle), .stall(st_stall),
        .phase(seq_phase)
    );

    assign st_tx_nf = !tx_full;
endmodule

// File: rtl/qspi_indirect_rd_chk.sv
module qspi_indirect_rd_chk
    import qspi_rd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input phase_e     phase,
    input logic       qspi_sck,
    input logic       qspi_cs_n,
    input logic [3:0] qspi_io_oe,
    input logic       st_idle,
    input logic       st_stall
);
    a_r1_cs_high_only_idle: assert property (@(posedge clk) disable iff (rst)
        qspi_cs_n |-> st_idle);

    a_r3_cmd_one_line: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD) |-> (qspi_io_oe == 4'b0001));

    a_r8_done_no_clock: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |-> !qspi_sck);

    a_r9_stall_no_clock: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> !qspi_sck);

    a_r10_release_after_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(qspi_cs_n) |-> $past(st_idle));

    a_r11_lines_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY || phase == PH_DATA || phase == PH_DONE || phase == PH_HOLD)
        |-> (qspi_io_oe == 4'h0));
endmodule

bind qspi_indirect_rd qspi_indirect_rd_chk u_chk (
    .clk(clk), .rst(rst), .phase(seq_phase), .qspi_sck(qspi_sck),
    .qspi_cs_n(qspi_cs_n), .qspi_io_oe(qspi_io_oe), .st_idle(st_idle),
    .st_stall(st_stall)
);

// File: tb/qspi_indirect_rd_tb_top.sv
module qspi_indirect_rd_tb_top;
    logic clk = 0, rst = 1, sck_tick = 0;
    logic [7:0] cfg_opcode = 0, cfg_perf_byte = 0, tx_data = 0;
    logic cfg_addr4 = 0, cfg_quad = 0, cfg_perf_en = 0, cfg_prefetch = 0;
    logic [4:0] cfg_dummy = 0;
    logic [7:0] cfg_rx_count = 0;
    logic cs_hold = 0, rx_flush = 0, tx_wr = 0, rx_rd = 0;
    logic [7:0] rx_data;
    logic st_idle, st_tx_nf, st_rx_empty, st_stall, qspi_cs_n, qspi_sck;
    logic [3:0] qspi_io_out, qspi_io_oe, qspi_io_in = 0;

    int checks = 0, errors = 0, sc = 0, drv_slots = 0, dum_slots = 0;
    bit quad_m = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    qspi_indirect_rd dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int i);
        return 8'(8'h3C + i * 71);
    endfunction

    task automatic exp_byte(input logic [7:0] b, input bit q);
        if (q) begin
            exp_q.push_back({4'hF, b[7:4]});
            exp_q.push_back({4'hF, b[3:0]});
        end else begin
            for (int i = 7; i >= 0; i--) exp_q.push_back({4'b0001, 3'b000, b[i]});
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1; tx_data = b;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic rd_byte(input logic [7:0] e, input string req);
        int n = 0;
        @(negedge clk);
        while (st_rx_empty && n < 500) begin @(negedge clk); n++; end
        chk(rx_data == e, req, rx_data, e);
        rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask

    // Bit-slot tick: one pulse every second cycle.
    initial forever begin
        @(negedge clk); sck_tick = ~sck_tick;
    end

    // Monitor and flash model: compares driven slots, answers read slots.
    initial forever begin
        @(negedge clk); #1;
        if (qspi_cs_n) sc = 0;
        else if (qspi_sck) begin
            if (sc < drv_slots) begin
                logic [7:0] e;
                string tag;
                tag = (sc < 8) ? "R3" : (exp_q.size() <= (quad_m ? 2 : 8) && cfg_perf_en) ? "R5" : "R4";
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
                chk({qspi_io_oe, qspi_io_out} === e, tag, {qspi_io_oe, qspi_io_out}, e);
            end else begin
                int d;
                d = sc - drv_slots;
                chk(qspi_io_oe == 4'h0, "R6 R11", qspi_io_oe, 0);
                if (d < dum_slots) qspi_io_in = 4'b1010 ^ 4'(d);
                else begin
                    int k;
                    logic [7:0] b;
                    k = d - dum_slots;
                    if (quad_m) begin
                        b = fb(k / 2);
                        qspi_io_in = (k % 2) ? b[3:0] : b[7:4];
                    end else begin
                        b = fb(k / 8);
                        qspi_io_in = {2'b11, b[7 - (k % 8)], 1'b1};
                    end
                end
            end
            sc++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int n;
        cycles(5); rst = 0; cycles(2);
        chk(st_idle == 1, "R1", st_idle, 1);
        chk(qspi_cs_n == 1, "R1", qspi_cs_n, 1);
        chk(qspi_io_oe == 0, "R1", qspi_io_oe, 0);
        chk(st_rx_empty == 1 && st_tx_nf == 1, "R1 R12", {st_rx_empty, st_tx_nf}, 3);
        chk(st_stall == 0, "R1", st_stall, 0);

        // Frame A: single line, 3-byte address, no mode byte, 8 dummies, 5 bytes.
        cfg_opcode = 8'h0B; cfg_addr4 = 0; cfg_quad = 0; cfg_perf_en = 0;
        cfg_dummy = 8; cfg_rx_count = 5; quad_m = 0;
        exp_byte(8'h0B, 0); exp_byte(8'h12, 0); exp_byte(8'h34, 0); exp_byte(8'h56, 0);
        drv_slots = 32; dum_slots = 8;
        push_tx(8'h12); cycles(20);
        chk(qspi_cs_n == 1, "R2", qspi_cs_n, 1);
        cfg_prefetch = 1; cycles(60);
        chk(sc == 16 && qspi_cs_n == 0, "R4", sc, 16);
        push_tx(8'h34); push_tx(8'h56);
        n = 0;
        while (sc < 80 && n < 2000) begin cycles(1); n++; end
        cycles(30);
        chk(sc == 80, "R8", sc, 80);
        chk(st_idle == 0 && qspi_cs_n == 0, "R8", {st_idle, qspi_cs_n}, 0);
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        for (int i = 0; i < 5; i++) rd_byte(fb(i), "R7");
        cycles(1);
        chk(st_rx_empty == 1, "R12", st_rx_empty, 1);
        cs_hold = 1; cycles(3);
        chk(st_idle == 1 && qspi_cs_n == 0, "R10", {st_idle, qspi_cs_n}, 2);
        cs_hold = 0; cycles(3);
        chk(qspi_cs_n == 1, "R10", qspi_cs_n, 1);

        // Frame B: quad, 4-byte address, mode byte, 4 dummies, unbounded.
        cfg_opcode = 8'hEB; cfg_addr4 = 1; cfg_quad = 1; cfg_perf_en = 1;
        cfg_perf_byte = 8'hA0; cfg_dummy = 4; cfg_rx_count = 0; quad_m = 1;
        exp_byte(8'hEB, 0);
        exp_byte(8'h9A, 1); exp_byte(8'hBC, 1); exp_byte(8'hDE, 1); exp_byte(8'hF1, 1);
        exp_byte(8'hA0, 1);
        drv_slots = 18; dum_slots = 4;
        push_tx(8'h9A); push_tx(8'hBC); push_tx(8'hDE); push_tx(8'hF1);
        n = 0;
        while (!st_stall && n < 2000) begin cycles(1); n++; end
        cycles(30);
        chk(sc == 38, "R9", sc, 38);
        chk(st_stall == 1 && st_rx_empty == 0, "R9", {st_stall, st_rx_empty}, 2);
        cs_hold = 1; cycles(3);
        chk(st_idle == 1 && qspi_cs_n == 0, "R10", {st_idle, qspi_cs_n}, 2);
        for (int i = 0; i < 3; i++) rd_byte(fb(i), "R7");
        chk(sc == 38, "R10", sc, 38);
        rx_flush = 1; cycles(1); rx_flush = 0; cycles(1);
        chk(st_rx_empty == 1 && st_stall == 0, "R10", {st_rx_empty, st_stall}, 2);
        cs_hold = 0; cycles(3);
        chk(qspi_cs_n == 1, "R10", qspi_cs_n, 1);

        // Transmit FIFO depth.
        cfg_prefetch = 0;
        for (int i = 0; i < 7; i++) push_tx(8'(i));
        chk(st_tx_nf == 1, "R12", st_tx_nf, 1);
        push_tx(8'h77); cycles(1);
        chk(st_tx_nf == 0, "R12", st_tx_nf, 0);
        chk(qspi_cs_n == 1, "R2", qspi_cs_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule